// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This unit forms the 12-bit data memory address used by every operand access of a small 8-bit processor core. The data space is 16 banks of 256 bytes. An operand can be reached in three direct ways. The first is banked, where a 4-bit bank register supplies the upper nibble and the 8-bit opcode field supplies the lower byte. The second is the shared window, which needs no bank register: the lower half of the 8-bit field lands at the bottom of bank 0 and the upper half lands at the top of bank 15. The third is a full 12-bit address carried by a two-word instruction.

The unit also supports indirect access through three 12-bit pointer registers. An indirect access can leave its pointer unchanged, step it down or up after use, step it up before use, or add the signed working-register value without moving the pointer. The effective address and the implemented-bank flag are combinational from the current inputs and pointer state. Pointer changes, whether automatic steps or explicit loads, take effect at the clock edge that ends the access.

Top module: `dmem_addr_gen`

## Requirements
- R1: With addrMode = 0 and accessSel = 1, effAddr = {bankSel, fileAddr}.
- R2: With addrMode = 0 and accessSel = 0, bankSel is ignored; fileAddr 0x00..0x7F gives effAddr 0x000..0x07F, and fileAddr 0x80..0xFF gives 0xF80..0xFFF.
- R3: With addrMode = 1, effAddr = directAddr; bankSel and fileAddr have no effect.
- R4: With addrMode = 2 or 7, effAddr equals the selected pointer and the pointer is unchanged; fileAddr is ignored. ptrSel 0, 1 and 2 pick pointers 0, 1 and 2, and ptrSel 3 also picks pointer 2.
- R5: With addrMode = 3 (post-decrement) or 4 (post-increment), effAddr is the pointer's current value, and after the edge the pointer is that value minus or plus 1, modulo 4096.
- R6: With addrMode = 5 (pre-increment), effAddr is the pointer plus 1 modulo 4096, and after the edge the pointer holds that same value.
- R7: With addrMode = 6, effAddr is the pointer plus the working register read as a signed 8-bit value, modulo 4096; the pointer is unchanged.
- R8: Automatic pointer steps happen only in a cycle with accessEn = 1. With accessEn = 0 the address is still produced, but no pointer moves.
- R9: When ldEn = 1 and ldSel is 0..2, that pointer takes ldValue at the edge, and this load wins over a same-cycle automatic step of the same pointer. A step of a different pointer in the same cycle still happens. ldSel = 3 loads nothing.
- R10: unimpl = 1 exactly when effAddr[11:8] is one of banks 6..14.
- R11: After reset all three pointers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fileAddr | input | 8 | File field of the opcode |
| accessSel | input | 1 | 1 = use bank register, 0 = shared window |
| bankSel | input | 4 | Bank register value |
| addrMode | input | 3 | Addressing mode code (0..7, see requirements) |
| directAddr | input | 12 | Full address from a two-word instruction |
| ptrSel | input | 2 | Pointer chosen for indirect modes |
| wreg | input | 8 | Working register value |
| accessEn | input | 1 | Access takes place this cycle (allows pointer steps) |
| ldEn | input | 1 | Pointer load strobe |
| ldSel | input | 2 | Pointer to load (3 = none) |
| ldValue | input | 12 | Value to load |
| effAddr | output | 12 | Effective data address |
| unimpl | output | 1 | Address lies in an unimplemented bank |
| ptrOut | output | 36 | Pointers; pointer k at bits [12k+11:12k] |

## Verification
An explicit pointer load and an automatic step can land in the same cycle, either on the same pointer or on two different ones. The bench provokes this by issuing a post-increment or post-decrement access while a load strobe targets the stepped pointer, and in another cycle a different pointer. It then judges the result from the pointer values read on the next access. The expected value is the loaded one in the first case, and in the second case both the loaded and the stepped value.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int ADDR_W    = 12;
  localparam int OFS_W     = 8;
  localparam int BANK_W    = ADDR_W - OFS_W;
  localparam int NPTR      = 3;
  localparam int PSEL_W    = 2;
  localparam int NBANK     = 1 << BANK_W;
  localparam logic [NBANK-1:0] IMPL_MASK = 16'h803F;

  typedef enum logic [2:0] {
    MODE_FILE    = 3'd0,
    MODE_FULL    = 3'd1,
    MODE_IND     = 3'd2,
    MODE_POSTDEC = 3'd3,
    MODE_POSTINC = 3'd4,
    MODE_PREINC  = 3'd5,
    MODE_PLUSW   = 3'd6,
    MODE_IND_ALT = 3'd7
  } amode_e;

  typedef struct packed {
    logic              selFull;
    logic              selPtr;
    logic              useBank;
    logic [PSEL_W-1:0] ptrIdx;
    logic              preInc;
    logic              addW;
    logic              stepDown;
    logic              writeBack;
  } strobe_t;
endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic [2:0]        addrMode,
  input  logic              accessSel,
  input  logic [PSEL_W-1:0] ptrSel,
  input  logic              accessEn,
  output strobe_t           strobe
);
  localparam logic [PSEL_W-1:0] LAST_PTR = PSEL_W'(NPTR - 1);

  amode_e mode;
  logic   steps;

  assign mode = amode_e'(addrMode);

  always_comb begin
    strobe         = '0;
    steps          = 1'b0;
    strobe.useBank = accessSel;
    strobe.ptrIdx  = (ptrSel > LAST_PTR) ? LAST_PTR : ptrSel;
    unique case (mode)
      MODE_FILE:    ;
      MODE_FULL:    strobe.selFull = 1'b1;
      MODE_IND,
      MODE_IND_ALT: strobe.selPtr = 1'b1;
      MODE_POSTDEC: begin
        strobe.selPtr   = 1'b1;
        strobe.stepDown = 1'b1;
        steps           = 1'b1;
      end
      MODE_POSTINC: begin
        strobe.selPtr = 1'b1;
        steps         = 1'b1;
      end
      MODE_PREINC: begin
        strobe.selPtr = 1'b1;
        strobe.preInc = 1'b1;
        steps         = 1'b1;
      end
      MODE_PLUSW: begin
        strobe.selPtr = 1'b1;
        strobe.addW   = 1'b1;
      end
      default: ;
    endcase
    strobe.writeBack = steps & accessEn;
  end
endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [OFS_W-1:0]  fileAddr,
  input  logic [ADDR_W-1:0] directAddr,
  input  logic [OFS_W-1:0]  wreg,
  input  logic              ldEn,
  input  logic [PSEL_W-1:0] ldSel,
  input  logic [ADDR_W-1:0] ldValue,
  output logic [ADDR_W-1:0] effAddr,
  output logic              unimpl,
  output logic [NPTR*ADDR_W-1:0] ptrOut
);
  logic [ADDR_W-1:0] ptrReg [NPTR];
  logic [ADDR_W-1:0] curPtr, incPtr, decPtr, sumW, nextPtr, ptrAddr, fileMapped;

  assign curPtr  = ptrReg[strobe.ptrIdx];
  assign incPtr  = curPtr + ADDR_W'(1);
  assign decPtr  = curPtr - ADDR_W'(1);
  assign sumW    = curPtr + {{(ADDR_W-OFS_W){wreg[OFS_W-1]}}, wreg};
  assign nextPtr = strobe.stepDown ? decPtr : incPtr;

  always_comb begin
    if (strobe.preInc)    ptrAddr = incPtr;
    else if (strobe.addW) ptrAddr = sumW;
    else                  ptrAddr = curPtr;
  end

  // shared window: top bit of the field picks bottom of bank 0 or top of last bank
  assign fileMapped = strobe.useBank ? {bankSel, fileAddr}
                                     : {{BANK_W{fileAddr[OFS_W-1]}}, fileAddr};

  always_comb begin
    if (strobe.selFull)     effAddr = directAddr;
    else if (strobe.selPtr) effAddr = ptrAddr;
    else                    effAddr = fileMapped;
  end

  assign unimpl = ~IMPL_MASK[effAddr[ADDR_W-1 -: BANK_W]];

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    logic loadHit, stepHit;
    assign loadHit = ldEn && (ldSel == PSEL_W'(k));
    assign stepHit = strobe.writeBack && (strobe.ptrIdx == PSEL_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        ptrReg[k] <= '0;
      else if (loadHit) ptrReg[k] <= ldValue;
      else if (stepHit) ptrReg[k] <= nextPtr;
    end

    assign ptrOut[k*ADDR_W +: ADDR_W] = ptrReg[k];
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  fileAddr,
  input  logic        accessSel,
  input  logic [3:0]  bankSel,
  input  logic [2:0]  addrMode,
  input  logic [11:0] directAddr,
  input  logic [1:0]  ptrSel,
  input  logic [7:0]  wreg,
  input  logic        accessEn,
  input  logic        ldEn,
  input  logic [1:0]  ldSel,
  input  logic [11:0] ldValue,
  output logic [11:0] effAddr,
  output logic        unimpl,
  output logic [35:0] ptrOut
);
  strobe_t strobe;

  dag_ctrl u_ctrl (
    .addrMode (addrMode),
    .accessSel(accessSel),
    .ptrSel   (ptrSel),
    .accessEn (accessEn),
    .strobe   (strobe)
  );

  dag_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bankSel   (bankSel),
    .fileAddr  (fileAddr),
    .directAddr(directAddr),
    .wreg      (wreg),
    .ldEn      (ldEn),
    .ldSel     (ldSel),
    .ldValue   (ldValue),
    .effAddr   (effAddr),
    .unimpl    (unimpl),
    .ptrOut    (ptrOut)
  );
endmodule

// File: rtl/dmem_addr_gen_chk.sv
module dmem_addr_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  fileAddr,
  input logic        accessSel,
  input logic [3:0]  bankSel,
  input logic [2:0]  addrMode,
  input logic [11:0] directAddr,
  input logic [1:0]  ptrSel,
  input logic [7:0]  wreg,
  input logic        accessEn,
  input logic        ldEn,
  input logic [1:0]  ldSel,
  input logic [11:0] ldValue,
  input logic [11:0] effAddr,
  input logic        unimpl,
  input logic [35:0] ptrOut
);
  logic [11:0] ptrArr [3];
  logic [1:0]  idx;
  logic [11:0] selPtr;

  always_comb begin
    for (int k = 0; k < 3; k++) ptrArr[k] = ptrOut[k*12 +: 12];
  end
  assign idx    = (ptrSel == 2'd3) ? 2'd2 : ptrSel;
  assign selPtr = ptrArr[idx];

  assert_banked_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 3'd0 && accessSel) |-> effAddr == {bankSel, fileAddr});

  assert_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 3'd0 && !accessSel) |->
      (effAddr[7:0] == fileAddr && effAddr[11:8] == (fileAddr[7] ? 4'hF : 4'h0)));

  assert_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 3'd1) |-> effAddr == directAddr);

  assert_plain_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((addrMode == 3'd2 || addrMode == 3'd7) && !ldEn) |=> $stable(ptrOut));

  assert_postinc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && addrMode == 3'd4 && !(ldEn && ldSel == idx))
      |=> ptrArr[$past(idx)] == $past(selPtr) + 12'd1);

  assert_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrMode == 3'd6) |-> effAddr == selPtr + {{4{wreg[7]}}, wreg});

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!accessEn && !ldEn) |=> $stable(ptrOut));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ldEn && ldSel != 2'd3) |=> ptrArr[$past(ldSel)] == $past(ldValue));

  assert_bank_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    unimpl == (effAddr[11:8] >= 4'd6 && effAddr[11:8] <= 4'd14));
endmodule

bind dmem_addr_gen dmem_addr_gen_chk u_chk (.*);

// File: tb/dmem_addr_gen_bench.sv
module dmem_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  fileAddr = '0;
  logic        accessSel = 1'b0;
  logic [3:0]  bankSel = '0;
  logic [2:0]  addrMode = '0;
  logic [11:0] directAddr = '0;
  logic [1:0]  ptrSel = '0;
  logic [7:0]  wreg = '0;
  logic        accessEn = 1'b0;
  logic        ldEn = 1'b0;
  logic [1:0]  ldSel = '0;
  logic [11:0] ldValue = '0;
  logic [11:0] effAddr;
  logic        unimpl;
  logic [35:0] ptrOut;

  always #4 clk = ~clk;

  dmem_addr_gen u_dmem_addr_gen (.*);

  typedef struct {
    logic [11:0] addr;
    logic        flag;
    logic [35:0] ptrs;
    string       tag;
  } item_t;

  item_t       q[$];
  logic [11:0] mdl [3];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  task automatic drive(input logic [2:0] m, input logic as, input logic [3:0] bk,
                       input logic [7:0] f, input logic [11:0] d, input logic [1:0] ps,
                       input logic [7:0] w, input logic en, input logic ld,
                       input logic [1:0] ls, input logic [11:0] lv, input string tag);
    item_t       it;
    int          ix;
    logic [11:0] cur, adr;
    @(negedge clk);
    addrMode = m; accessSel = as; bankSel = bk; fileAddr = f; directAddr = d;
    ptrSel = ps; wreg = w; accessEn = en; ldEn = ld; ldSel = ls; ldValue = lv;
    ix  = (ps == 2'd3) ? 2 : int'(ps);
    cur = mdl[ix];
    case (m)
      3'd0:    adr = as ? {bk, f} : (f[7] ? {4'hF, f} : {4'h0, f});
      3'd1:    adr = d;
      3'd5:    adr = cur + 12'd1;
      3'd6:    adr = cur + {{4{w[7]}}, w};
      default: adr = cur;
    endcase
    it.addr = adr;
    it.flag = !(adr[11:8] <= 4'd5 || adr[11:8] == 4'hF);
    it.ptrs = {mdl[2], mdl[1], mdl[0]};
    it.tag  = tag;
    q.push_back(it);
    if (en) begin
      if (m == 3'd3) mdl[ix] = cur - 12'd1;
      else if (m == 3'd4 || m == 3'd5) mdl[ix] = cur + 12'd1;
    end
    if (ld && ls != 2'd3) mdl[ls] = lv;
  endtask

  task automatic idle(input string tag);
    drive(3'd0, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b0, 1'b0, 2'd3, 12'h000, tag);
  endtask

  // monitor: pops expected items and compares once the combinational result is settled
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() != 0) begin
        it = q.pop_front();
        total++;
        if (effAddr !== it.addr) begin
          bad++;
          $display("FAIL %s effAddr act=%h exp=%h", it.tag, effAddr, it.addr);
        end
        total++;
        if (unimpl !== it.flag) begin
          bad++;
          $display("FAIL %s R10 unimpl act=%b exp=%b", it.tag, unimpl, it.flag);
        end
        total++;
        if (ptrOut !== it.ptrs) begin
          bad++;
          $display("FAIL %s ptrOut act=%h exp=%h", it.tag, ptrOut, it.ptrs);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R11 reset pointers");
    // R1 banked
    drive(3'd0, 1'b1, 4'h2, 8'h55, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R1 bank2");
    drive(3'd0, 1'b1, 4'h7, 8'h10, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R1 R10 bank7");
    drive(3'd0, 1'b1, 4'hF, 8'hC4, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R1 bank15");
    // R2 shared window
    drive(3'd0, 1'b0, 4'h9, 8'h83, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R2 upper half");
    drive(3'd0, 1'b0, 4'hB, 8'h7F, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R2 lower edge");
    drive(3'd0, 1'b0, 4'h3, 8'h80, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R2 upper edge");
    // R3 full direct
    drive(3'd1, 1'b1, 4'h1, 8'h22, 12'hA00, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R3 R10 bank10");
    drive(3'd1, 1'b0, 4'hE, 8'hFF, 12'h5FF, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R3 bank5");
    // R9 loads, ldSel 3 ignored
    drive(3'd0, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b0, 1'b1, 2'd0, 12'h123, "R9 load p0");
    drive(3'd0, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 12'hFFF, "R9 load p1");
    drive(3'd0, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b0, 1'b1, 2'd2, 12'h500, "R9 load p2");
    drive(3'd0, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 12'hAAA, "R9 ldSel3");
    // R4 plain indirect, ptrSel 3 alias, mode 7
    drive(3'd2, 1'b1, 4'h4, 8'h99, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R4 p0 plain");
    drive(3'd2, 1'b1, 4'h4, 8'h99, 12'h000, 2'd3, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R4 ptrSel3");
    drive(3'd7, 1'b0, 4'h4, 8'h11, 12'h000, 2'd1, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R4 mode7");
    // R5 post-inc with wrap, post-dec
    drive(3'd4, 1'b1, 4'h0, 8'h00, 12'h000, 2'd1, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R5 postinc p1");
    drive(3'd3, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R5 postinc wrap seen");
    drive(3'd3, 1'b1, 4'h0, 8'h00, 12'h000, 2'd1, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R5 postdec seen");
    idle("R5 postdec wrap seen");
    // R6 pre-increment
    drive(3'd5, 1'b1, 4'h0, 8'h00, 12'h000, 2'd2, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R6 preinc p2");
    drive(3'd5, 1'b1, 4'h0, 8'h00, 12'h000, 2'd2, 8'h00, 1'b1, 1'b0, 2'd0, 12'h000, "R6 preinc again");
    // R7 signed offset
    drive(3'd6, 1'b1, 4'h0, 8'h00, 12'h000, 2'd2, 8'h80, 1'b1, 1'b0, 2'd0, 12'h000, "R7 minus128");
    drive(3'd6, 1'b1, 4'h0, 8'h00, 12'h000, 2'd2, 8'h7F, 1'b1, 1'b1, 2'd0, 12'h010, "R7 plus127");
    drive(3'd6, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'hF0, 1'b1, 1'b0, 2'd0, 12'h000, "R7 to zero");
    drive(3'd6, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'hE0, 1'b1, 1'b0, 2'd0, 12'h000, "R7 wrap low");
    // R8 no step without accessEn
    drive(3'd4, 1'b1, 4'h0, 8'h00, 12'h000, 2'd2, 8'h00, 1'b0, 1'b0, 2'd0, 12'h000, "R8 postinc idle");
    drive(3'd5, 1'b1, 4'h0, 8'h00, 12'h000, 2'd1, 8'h00, 1'b0, 1'b0, 2'd0, 12'h000, "R8 preinc idle");
    // R9 same-cycle conflicts
    drive(3'd4, 1'b1, 4'h0, 8'h00, 12'h000, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0, 12'h300, "R9 pre-conflict");
    drive(3'd3, 1'b1, 4'h0, 8'h00, 12'h000, 2'd1, 8'h00, 1'b1, 1'b1, 2'd0, 12'h777, "R9 load won");
    drive(3'd4, 1'b1, 4'h0, 8'h00, 12'h000, 2'd3, 8'h00, 1'b1, 1'b1, 2'd3, 12'h123, "R9 both applied");
    idle("R9 ldSel3 with step");
    idle("R11 final state");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule